// File: doc/BRIEF.md
# Flash Row Write Controller

This block sits between a processor's register writes and a program-flash array. The processor loads a 64-byte staging buffer one byte at a time. Each byte goes to the slot picked by the low pointer bits, and the pointer can step forward after each load. The buffer is then committed to the flash as one whole, aligned row. Bytes or words cannot be programmed one at a time.

A commit is guarded. The write-enable bit must already be set, the two key bytes 55h and AAh must reach the unlock register in that order, and the very next register write must be a control write with the start bit set. Once a commit starts, the processor is stalled and a row-program request is held to the array for a fixed number of clock cycles, counted by an internal program timer. A one-cycle done pulse then ends the commit. The staging buffer keeps its contents after a commit.

The block tracks how many times each row has been programmed since its last erase. A third commit to a row is refused and flagged. An erase input clears that count for one row.

Top module: `flash_row_writer`

## Requirements
- R1: After reset the pointer is 0, all 64 staging bytes are 0, every row's program count is 0, write-enable is clear, and the stall, request, done and reject outputs are low.
- R2: A table write stores its byte in the staging slot given by pointer bits [5:0] and does not raise the row-program request. The staged bytes appear on `progData`, with slot k at bits [8k+7:8k].
- R3: A table write with `latPostInc` set advances the pointer by one, wrapping modulo 2^PTR_W. Without `latPostInc` the pointer does not move. A pointer write loads the pointer directly.
- R4: A commit starts only if write-enable is already 1, the last two unlock writes were 55h then AAh with no other register write after them, and the next register write is a control write with `ctlStart`=1. A control write always loads write-enable from `ctlWren`.
- R5: A wrong unlock byte, the keys in the wrong order, or any pointer, table or control write before the start resets the unlock sequence. The start bit is then ignored.
- R6: From the cycle after the start write, `flashStall` and `progReq` are high for exactly PROG_CYCLES cycles. Pointer, table, control, unlock and erase writes in that time have no effect.
- R7: `progRow` equals pointer bits [PTR_W-1:6] at the start write and holds that value for the whole commit.
- R8: `progDone` is high for exactly one cycle, in the first cycle after the stall ends. A new start needs a fresh unlock sequence.
- R9: The staging buffer is not cleared by a commit. `progData` stays the same across the commit and afterwards until the next table write.
- R10: A start aimed at a row already programmed twice since its last erase does not stall. Instead it pulses `progReject` for one cycle, and the row's count does not change.
- R11: An `eraseReq` when the block is not busy sets the program count of row `eraseRow` to zero. An erase during a commit is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ptrWrEn | input | 1 | Pointer register write strobe |
| ptrWrData | input | PTR_W | New pointer value |
| latWrEn | input | 1 | Table write strobe |
| latWrData | input | 8 | Byte to stage |
| latPostInc | input | 1 | Advance pointer after this table write |
| ctlWrEn | input | 1 | Control register write strobe |
| ctlWren | input | 1 | Write-enable value written |
| ctlStart | input | 1 | Start-commit bit written |
| unlockWrEn | input | 1 | Unlock register write strobe |
| unlockWrData | input | 8 | Unlock byte |
| eraseReq | input | 1 | Erase notification for one row |
| eraseRow | input | PTR_W-6 | Row that was erased |
| ptrOut | output | PTR_W | Current pointer |
| flashStall | output | 1 | Processor stall during a commit |
| progReq | output | 1 | Row-program request to the array |
| progRow | output | PTR_W-6 | Row being programmed |
| progData | output | 512 | Staged row bytes |
| progDone | output | 1 | Commit finished pulse |
| progReject | output | 1 | Commit refused for wear pulse |

## Verification
Some properties are checked by assertions on every cycle. A commit must end with a done pulse exactly as its timer runs out, and done never lasts two cycles. A stall can only begin right after an armed unlock with write-enable set. A refusal never overlaps a commit, no row count passes two, and the pointer, staged bytes and target row stay frozen while stalled.

Other behaviour only shows up in the bench's scenarios, because it depends on a series of writes: the broken unlock orderings, the exact commit length, the third-commit refusal, and the erase that is ignored mid-commit but works afterwards. The bench checks these against a behavioural reference model, cycle by cycle.

// File: rtl/flash_row_pkg.sv
package flash_row_pkg;

  // strobes from control to datapath, one per datapath action
  typedef struct packed {
    logic ptrLoad;
    logic latchWrite;
    logic postInc;
    logic commit;
    logic erase;
  } dpStrobe_t;

  typedef enum logic [1:0] {
    UNL_IDLE  = 2'd0,
    UNL_HALF  = 2'd1,
    UNL_ARMED = 2'd2
  } unlockState_t;

  localparam logic [7:0] UNLOCK_KEY_A = 8'h55;
  localparam logic [7:0] UNLOCK_KEY_B = 8'hAA;
  localparam logic [1:0] WEAR_LIMIT   = 2'd2;

endpackage

// File: rtl/flash_row_datapath.sv
module flash_row_datapath
  import flash_row_pkg::*;
#(
  parameter int ROW_BYTES = 64,
  parameter int PTR_W     = 9,
  localparam int IDX_W    = $clog2(ROW_BYTES),
  localparam int ROW_W    = PTR_W - IDX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  dpStrobe_t              strobe,
  input  logic [PTR_W-1:0]       ptrWrData,
  input  logic [7:0]             latWrData,
  input  logic [ROW_W-1:0]       eraseRow,
  output logic [PTR_W-1:0]       ptrQ,
  output logic [ROW_W-1:0]       progRow,
  output logic [ROW_BYTES*8-1:0] progData,
  output logic                   rowWorn
);

  localparam int NUM_ROWS = 1 << ROW_W;

  logic [ROW_W-1:0] ptrRow;
  logic [IDX_W-1:0] ptrIdx;
  logic [1:0]       wearCnt [NUM_ROWS];

  assign ptrRow = ptrQ[PTR_W-1:IDX_W];
  assign ptrIdx = ptrQ[IDX_W-1:0];

  // table pointer with optional post-increment
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ptrQ <= '0;
    else if (strobe.ptrLoad) ptrQ <= ptrWrData;
    else if (strobe.latchWrite && strobe.postInc) ptrQ <= ptrQ + 1'b1;
  end

  // staging buffer, one byte register per slot
  for (genvar i = 0; i < ROW_BYTES; i++) begin : g_slot
    logic [7:0] slotQ;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) slotQ <= '0;
      else if (strobe.latchWrite && ptrIdx == IDX_W'(i)) slotQ <= latWrData;
    end
    assign progData[i*8 +: 8] = slotQ;
  end

  // per-row program count since erase, saturating at the wear limit
  for (genvar r = 0; r < NUM_ROWS; r++) begin : g_wear
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wearCnt[r] <= '0;
      else if (strobe.erase && eraseRow == ROW_W'(r)) wearCnt[r] <= '0;
      else if (strobe.commit && ptrRow == ROW_W'(r) && wearCnt[r] != WEAR_LIMIT)
        wearCnt[r] <= wearCnt[r] + 2'd1;
    end

    p_wear_cap_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      wearCnt[r] <= WEAR_LIMIT);
  end

  assign rowWorn = (wearCnt[ptrRow] == WEAR_LIMIT);

  // target row latched at the start of a commit
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) progRow <= '0;
    else if (strobe.commit) progRow <= ptrRow;
  end

  p_buffer_keep_r9 : assert property (@(posedge clk) disable iff (!rst_n)
    !strobe.latchWrite |=> $stable(progData));

  p_commit_not_worn_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    strobe.commit |-> !rowWorn);

endmodule

// File: rtl/flash_row_control.sv
module flash_row_control
  import flash_row_pkg::*;
#(
  parameter int PROG_CYCLES = 80000,
  localparam int TMR_W      = $clog2(PROG_CYCLES + 1)
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ptrWrEn,
  input  logic       latWrEn,
  input  logic       latPostInc,
  input  logic       ctlWrEn,
  input  logic       ctlWren,
  input  logic       ctlStart,
  input  logic       unlockWrEn,
  input  logic [7:0] unlockWrData,
  input  logic       eraseReq,
  input  logic       rowWorn,
  output dpStrobe_t  strobe,
  output logic       busy,
  output logic       done,
  output logic       reject
);

  unlockState_t unlState, unlNext;
  logic             wrenQ;
  logic [TMR_W-1:0] timer;
  logic             idle, ctlHit, unlHit, otherHit, startOk;

  assign idle     = !busy;
  // one register write per cycle; pointer, table, control, unlock in that priority
  assign ctlHit   = idle && !ptrWrEn && !latWrEn && ctlWrEn;
  assign unlHit   = idle && !ptrWrEn && !latWrEn && !ctlWrEn && unlockWrEn;
  assign otherHit = idle && (ptrWrEn || latWrEn || ctlWrEn);
  assign startOk  = ctlHit && ctlStart && wrenQ && (unlState == UNL_ARMED);

  always_comb begin
    strobe            = '0;
    strobe.ptrLoad    = idle && ptrWrEn;
    strobe.latchWrite = idle && !ptrWrEn && latWrEn;
    strobe.postInc    = latPostInc;
    strobe.commit     = startOk && !rowWorn;
    strobe.erase      = idle && eraseReq;
  end

  // unlock sequencer: exact key order, anything else falls back to idle
  always_comb begin
    unlNext = unlState;
    if (otherHit) begin
      unlNext = UNL_IDLE;
    end else if (unlHit) begin
      if (unlState == UNL_IDLE && unlockWrData == UNLOCK_KEY_A) unlNext = UNL_HALF;
      else if (unlState == UNL_HALF && unlockWrData == UNLOCK_KEY_B) unlNext = UNL_ARMED;
      else unlNext = UNL_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) unlState <= UNL_IDLE;
    else        unlState <= unlNext;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      wrenQ <= 1'b0;
    else if (ctlHit) wrenQ <= ctlWren;
  end

  // program timer and completion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy   <= 1'b0;
      timer  <= '0;
      done   <= 1'b0;
      reject <= 1'b0;
    end else begin
      done   <= 1'b0;
      reject <= startOk && rowWorn;
      if (busy) begin
        if (timer == '0) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          timer <= timer - 1'b1;
        end
      end else if (strobe.commit) begin
        busy  <= 1'b1;
        timer <= TMR_W'(PROG_CYCLES - 1);
      end
    end
  end

  p_timer_end_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    busy && timer == '0 |=> !busy && done);

  p_done_pulse_r8 : assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_start_armed_r4 : assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(unlState == UNL_ARMED && wrenQ && ctlWrEn));

  p_reject_idle_r10 : assert property (@(posedge clk) disable iff (!rst_n)
    reject |-> !busy);

endmodule

// File: rtl/flash_row_writer.sv
module flash_row_writer
  import flash_row_pkg::*;
#(
  parameter int ROW_BYTES   = 64,
  parameter int PTR_W       = 9,
  parameter int PROG_CYCLES = 80000,
  localparam int IDX_W      = $clog2(ROW_BYTES),
  localparam int ROW_W      = PTR_W - IDX_W
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   ptrWrEn,
  input  logic [PTR_W-1:0]       ptrWrData,
  input  logic                   latWrEn,
  input  logic [7:0]             latWrData,
  input  logic                   latPostInc,
  input  logic                   ctlWrEn,
  input  logic                   ctlWren,
  input  logic                   ctlStart,
  input  logic                   unlockWrEn,
  input  logic [7:0]             unlockWrData,
  input  logic                   eraseReq,
  input  logic [ROW_W-1:0]       eraseRow,
  output logic [PTR_W-1:0]       ptrOut,
  output logic                   flashStall,
  output logic                   progReq,
  output logic [ROW_W-1:0]       progRow,
  output logic [ROW_BYTES*8-1:0] progData,
  output logic                   progDone,
  output logic                   progReject
);

  dpStrobe_t strobe;
  logic      busy, rowWorn;

  flash_row_control #(.PROG_CYCLES(PROG_CYCLES)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .ptrWrEn(ptrWrEn), .latWrEn(latWrEn), .latPostInc(latPostInc),
    .ctlWrEn(ctlWrEn), .ctlWren(ctlWren), .ctlStart(ctlStart),
    .unlockWrEn(unlockWrEn), .unlockWrData(unlockWrData),
    .eraseReq(eraseReq), .rowWorn(rowWorn),
    .strobe(strobe), .busy(busy), .done(progDone), .reject(progReject)
  );

  flash_row_datapath #(.ROW_BYTES(ROW_BYTES), .PTR_W(PTR_W)) u_dp (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .ptrWrData(ptrWrData), .latWrData(latWrData), .eraseRow(eraseRow),
    .ptrQ(ptrOut), .progRow(progRow), .progData(progData), .rowWorn(rowWorn)
  );

  assign flashStall = busy;
  assign progReq    = busy;

  p_frozen_r6 : assert property (@(posedge clk) disable iff (!rst_n)
    flashStall && $past(flashStall) |-> $stable(ptrOut) && $stable(progData) && $stable(progRow));

endmodule

// File: tb/flash_row_writer_tb.sv
module flash_row_writer_tb;

  localparam int PTR_W = 9;
  localparam int ROW_W = PTR_W - 6;
  localparam int PROG  = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ptrWrEn = 0, latWrEn = 0, latPostInc = 0, ctlWrEn = 0, ctlWren = 0, ctlStart = 0;
  logic unlockWrEn = 0, eraseReq = 0;
  logic [PTR_W-1:0] ptrWrData = '0;
  logic [7:0] latWrData = '0, unlockWrData = '0;
  logic [ROW_W-1:0] eraseRow = '0;
  logic [PTR_W-1:0] ptrOut;
  logic flashStall, progReq, progDone, progReject;
  logic [ROW_W-1:0] progRow;
  logic [511:0] progData;

  int checks = 0, errors = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  flash_row_writer #(.ROW_BYTES(64), .PTR_W(PTR_W), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .ptrWrEn(ptrWrEn), .ptrWrData(ptrWrData),
    .latWrEn(latWrEn), .latWrData(latWrData), .latPostInc(latPostInc),
    .ctlWrEn(ctlWrEn), .ctlWren(ctlWren), .ctlStart(ctlStart),
    .unlockWrEn(unlockWrEn), .unlockWrData(unlockWrData),
    .eraseReq(eraseReq), .eraseRow(eraseRow), .ptrOut(ptrOut),
    .flashStall(flashStall), .progReq(progReq), .progRow(progRow),
    .progData(progData), .progDone(progDone), .progReject(progReject)
  );

  // behavioural reference model
  int mHold[64];
  int mCount[8];
  int mPtr, mUnl, mLeft, mRow;
  bit mWren, mBusy, mDone, mReject;

  task automatic model_reset();
    foreach (mHold[i]) mHold[i] = 0;
    foreach (mCount[i]) mCount[i] = 0;
    mPtr = 0; mUnl = 0; mLeft = 0; mRow = 0;
    mWren = 0; mBusy = 0; mDone = 0; mReject = 0;
  endtask

  initial model_reset();

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      mDone = 0;
      mReject = 0;
      if (mBusy) begin
        mLeft = mLeft - 1;
        if (mLeft == 0) begin mBusy = 0; mDone = 1; end
      end else begin
        if (eraseReq) mCount[int'(eraseRow)] = 0;
        if (ptrWrEn) begin
          mPtr = int'(ptrWrData); mUnl = 0;
        end else if (latWrEn) begin
          mHold[mPtr % 64] = int'(latWrData);
          if (latPostInc) mPtr = (mPtr + 1) % (1 << PTR_W);
          mUnl = 0;
        end else if (ctlWrEn) begin
          if (ctlStart && mWren && mUnl == 2) begin
            if (mCount[mPtr / 64] >= 2) mReject = 1;
            else begin
              mCount[mPtr / 64]++;
              mBusy = 1; mLeft = PROG; mRow = mPtr / 64;
            end
          end
          mWren = ctlWren; mUnl = 0;
        end else if (unlockWrEn) begin
          if (mUnl == 0 && unlockWrData == 8'h55) mUnl = 1;
          else if (mUnl == 1 && unlockWrData == 8'hAA) mUnl = 2;
          else mUnl = 0;
        end
      end
    end
  end

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [511:0] expData;
      for (int i = 0; i < 64; i++) expData[i*8 +: 8] = 8'(mHold[i]);
      check(flashStall == mBusy, "R6 stall", flashStall, mBusy);
      check(progReq == mBusy, "R6 request", progReq, mBusy);
      check(int'(ptrOut) == mPtr, "R3 pointer", ptrOut, mPtr);
      check(progDone == mDone, "R8 done", progDone, mDone);
      check(progReject == mReject, "R10 reject", progReject, mReject);
      check(int'(progRow) == mRow, "R7 row", progRow, mRow);
      check(progData == expData, "R2 R9 staged data", progData[63:0], expData[63:0]);
    end
  end

  task automatic wr_ptr(input int v);
    ptrWrEn = 1; ptrWrData = PTR_W'(v); @(negedge clk); ptrWrEn = 0;
  endtask
  task automatic wr_lat(input int v, input bit inc);
    latWrEn = 1; latWrData = 8'(v); latPostInc = inc; @(negedge clk); latWrEn = 0; latPostInc = 0;
  endtask
  task automatic wr_ctl(input bit wren, input bit start);
    ctlWrEn = 1; ctlWren = wren; ctlStart = start; @(negedge clk);
    ctlWrEn = 0; ctlStart = 0;
  endtask
  task automatic wr_unl(input int v);
    unlockWrEn = 1; unlockWrData = 8'(v); @(negedge clk); unlockWrEn = 0;
  endtask
  task automatic do_erase(input int r);
    eraseReq = 1; eraseRow = ROW_W'(r); @(negedge clk); eraseReq = 0;
  endtask

  // wait out a commit, poking writes that must be ignored, and time it
  task automatic ride_commit(input string tag, input bit eraseMid);
    int cnt = 0;
    while (flashStall && cnt < 10 * PROG) begin
      latWrEn = (cnt == 3); latWrData = 8'hEE; latPostInc = (cnt == 3);
      ptrWrEn = (cnt == 5); ptrWrData = '0;
      unlockWrEn = (cnt == 7); unlockWrData = 8'h55;
      eraseReq = eraseMid && (cnt == 9); eraseRow = 3'd2;
      cnt++;
      @(negedge clk);
    end
    latWrEn = 0; latPostInc = 0; ptrWrEn = 0; unlockWrEn = 0; eraseReq = 0;
    check(cnt == PROG, {tag, " R6 stall length"}, cnt, PROG);
    check(progDone == 1'b1, {tag, " R8 done after stall"}, progDone, 1);
    @(negedge clk);
    check(progDone == 1'b0, {tag, " R8 done one cycle"}, progDone, 0);
  endtask

  task automatic unlock_start();
    wr_unl(8'h55); wr_unl(8'hAA); wr_ctl(1, 1);
  endtask

  initial begin
    #(200_000 * 10);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(ptrOut == '0, "R1 pointer reset", ptrOut, 0);
    check(progData == '0, "R1 buffer reset", progData[63:0], 0);
    check(!flashStall && !progReq && !progDone && !progReject, "R1 outputs reset", flashStall, 0);
    rst_n = 1;
    @(negedge clk);

    // R2 R3 fill the buffer with post-increment
    for (int i = 0; i < 64; i++) wr_lat(i * 3 + 1, 1);
    check(ptrOut == 9'd64, "R3 pointer after 64 loads", ptrOut, 64);
    check(progData[15:8] == 8'd4, "R2 slot 1 contents", progData[15:8], 4);
    check(!progReq, "R2 table write no request", progReq, 0);
    wr_lat(8'h5A, 0);
    check(ptrOut == 9'd64 && progData[7:0] == 8'h5A, "R3 no increment", ptrOut, 64);

    // R4 no write-enable: keys and start do nothing
    wr_ctl(0, 0); unlock_start();
    check(!flashStall, "R4 start without enable", flashStall, 0);
    // R5 broken sequences (enable is now set)
    wr_unl(8'hAA); wr_unl(8'h55); wr_ctl(1, 1);
    check(!flashStall, "R5 reversed keys", flashStall, 0);
    wr_unl(8'h55); wr_ptr(9'h085); wr_unl(8'hAA); wr_ctl(1, 1);
    check(!flashStall, "R5 pointer write inside keys", flashStall, 0);
    wr_unl(8'h55); wr_unl(8'hAA); wr_lat(8'h77, 0); wr_ctl(1, 1);
    check(!flashStall, "R5 table write before start", flashStall, 0);
    wr_unl(8'h55); wr_unl(8'h11); wr_unl(8'hAA); wr_ctl(1, 1);
    check(!flashStall, "R5 wrong key byte", flashStall, 0);

    // R4 R6 R7 R8 proper commit into row 2
    unlock_start();
    check(flashStall && progRow == 3'd2, "R7 commit row 2", progRow, 2);
    ride_commit("first", 0);
    check(progData[8*5 +: 8] == 8'h77, "R9 buffer kept after commit", progData[8*5 +: 8], 8'h77);
    wr_ctl(1, 1);
    check(!flashStall, "R8 start needs new unlock", flashStall, 0);

    // R10 second commit ok, third refused
    unlock_start(); ride_commit("second", 0);
    wr_unl(8'h55); wr_unl(8'hAA);
    ctlWrEn = 1; ctlWren = 1; ctlStart = 1; @(negedge clk); ctlWrEn = 0; ctlStart = 0;
    check(progReject && !flashStall, "R10 third commit refused", progReject, 1);
    @(negedge clk);
    check(!progReject, "R10 reject one cycle", progReject, 0);

    // R11 erase frees the row; erase mid-commit ignored
    do_erase(2);
    unlock_start(); ride_commit("after erase", 1);
    unlock_start(); ride_commit("count two", 0);
    unlock_start();
    check(!flashStall && progReject, "R11 mid-commit erase ignored", flashStall, 0);
    // other rows unaffected
    wr_ptr(9'h1C0); unlock_start();
    check(flashStall && progRow == 3'd7, "R7 row 7 commit", progRow, 7);
    ride_commit("row7", 0);

    // R3 pointer wrap
    wr_ptr(9'h1FF); wr_lat(8'h99, 1);
    check(ptrOut == '0 && progData[8*63 +: 8] == 8'h99, "R3 pointer wrap", ptrOut, 0);

    repeat (3) @(negedge clk);
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule